// File: doc/BRIEF.md
# Partitioned Virtual FIFO Writer

This block is the write side of a RAM that is divided into up to eight independent circular FIFOs. Each write names a partition with a 3-bit address, and the word is stored at that partition's current write pointer. A line is `WPL` words wide. The pointer moves to a new line in three cases: the last word of a line is written, a word carries the end-of-packet flag, or the line-termination strobe is raised. A line that has been finished counts toward the partition's occupancy. A per-partition pop input gives a line back when the read side has drained it.

The base line, size in lines and fill level of every partition are static configuration inputs. Several traffic sources may share one partition, so the logic works by partition only. The full output always describes the partition on the address bus. It is raised once that partition's occupancy has passed its fill level, which is a threshold below the true capacity. Each stored word carries two tags: the end-of-packet flag, and an error flag that is only accepted when it arrives together with end-of-packet. A simple registered read port lets the read side fetch any stored word and its tags.

Top module: `pvfifo_writer`

## Requirements
- R1: With `wr_en` high and room in the partition, `wr_data` is stored at RAM address `line*WPL + word`. Here `line` is the partition base plus its line offset modulo `LINES`, and `word` is the word index within the line. The word index then advances. After word `WPL-1` the next line starts at word 0 and occupancy rises by one.
- R2: An accepted write with `wr_eop` high is tagged end-of-packet. The following write to that partition starts at word 0 of the next line, and occupancy rises by one.
- R3: An accepted write with both `wr_eop` and `wr_err` high is tagged errored. A write with `wr_err` high and `wr_eop` low stores an error tag of 0 and sets the sticky `proto_err` output.
- R4: `wr_term` advances the addressed partition to its next line and adds one to occupancy. This holds with or without a write in the same cycle; with a write, the word goes into the current line first.
- R5: The line offset wraps from `size-1` back to 0, so the line after the last line of a partition is its base line.
- R6: `full` is 1 exactly when the occupancy of the partition on `wr_part` is greater than that partition's fill level.
- R7: When the addressed partition's occupancy equals its size, a write or termination is dropped. The RAM and the pointer are left unchanged, and that partition's sticky `overflow` bit is set.
- R8: `pop[p]` lowers partition p's occupancy by one. A pop while occupancy is 0 has no effect.
- R9: After reset every occupancy is 0, and `full`, `overflow` and `proto_err` are 0.
- R10: `rd_data`, `rd_eop` and `rd_err` show the word at `rd_addr` one clock after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_part | input | 3 | Partition address |
| wr_data | input | DW | Write word |
| wr_eop | input | 1 | End of packet |
| wr_err | input | 1 | Packet error, valid only with end of packet |
| wr_term | input | 1 | Line termination strobe |
| cfg_base | input | NPART*LA_W | Base line of each partition |
| cfg_size | input | NPART*(LA_W+1) | Size in lines of each partition |
| cfg_level | input | NPART*(LA_W+1) | Fill level of each partition |
| pop | input | NPART | Release one line per partition |
| rd_addr | input | LA_W+WO_W | Read address (line*WPL + word) |
| full | output | 1 | Addressed partition has passed its fill level |
| overflow | output | NPART | Sticky dropped-write flags |
| proto_err | output | 1 | Sticky error-without-end-of-packet flag |
| rd_data | output | DW | Word read |
| rd_eop | output | 1 | End-of-packet tag of word read |
| rd_err | output | 1 | Error tag of word read |

## Verification
Writes, terminations and pops are taken at a clock edge. After that edge the new occupancy, and therefore `full`, `overflow` and `proto_err`, are visible with no further delay, because `full` is decoded without a register from the stored occupancy and the current `wr_part`. A stored word comes back one edge after its address is put on `rd_addr`. The bench drives on falling edges, reads flags at the next falling edge after the edge that took the stimulus, and for readback presents the address at one falling edge and samples at the next.

// File: rtl/pvfifo_writer.sv
module pvfifo_writer #(
  parameter int DW    = 32,
  parameter int NPART = 8,
  parameter int LINES = 16,
  parameter int WPL   = 4,
  localparam int PA_W = $clog2(NPART),
  localparam int LA_W = $clog2(LINES),
  localparam int WO_W = $clog2(WPL),
  localparam int SZ_W = LA_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PA_W-1:0]        wr_part,
  input  logic [DW-1:0]          wr_data,
  input  logic                   wr_eop,
  input  logic                   wr_err,
  input  logic                   wr_term,
  input  logic [NPART*LA_W-1:0]  cfg_base,
  input  logic [NPART*SZ_W-1:0]  cfg_size,
  input  logic [NPART*SZ_W-1:0]  cfg_level,
  input  logic [NPART-1:0]       pop,
  input  logic [LA_W+WO_W-1:0]   rd_addr,
  output logic                   full,
  output logic [NPART-1:0]       overflow,
  output logic                   proto_err,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_eop,
  output logic                   rd_err
);

  logic [NPART-1:0][SZ_W-1:0] occ;
  logic [NPART-1:0][LA_W-1:0] off;
  logic [NPART-1:0][WO_W-1:0] wi;
  logic [DW+1:0] mem [LINES*WPL];
  logic [DW+1:0] rd_q;

  logic [LA_W-1:0] base_a;
  logic [SZ_W-1:0] size_a, level_a;
  logic [LA_W-1:0] line_a;
  logic            room, acc, adv, drop;
  logic [SZ_W-1:0] off_inc;
  logic [LA_W-1:0] off_next;

  assign base_a  = cfg_base[wr_part*LA_W +: LA_W];
  assign size_a  = cfg_size[wr_part*SZ_W +: SZ_W];
  assign level_a = cfg_level[wr_part*SZ_W +: SZ_W];
  assign line_a  = base_a + off[wr_part];

  assign room = occ[wr_part] < size_a;
  assign acc  = wr_en & room;
  assign adv  = room & (wr_term | (wr_en & (wr_eop | (wi[wr_part] == WO_W'(WPL-1)))));
  assign drop = (wr_en | wr_term) & ~room;

  assign off_inc  = {1'b0, off[wr_part]} + SZ_W'(1);
  assign off_next = (off_inc >= size_a) ? '0 : off_inc[LA_W-1:0];

  assign full = occ[wr_part] > level_a;

  genvar p;
  generate
    for (p = 0; p < NPART; p++) begin : g_part
      logic sel, inc, dec;
      assign sel = wr_part == PA_W'(p);
      assign inc = sel & adv;
      assign dec = pop[p] & (occ[p] != '0);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          occ[p]      <= '0;
          off[p]      <= '0;
          wi[p]       <= '0;
          overflow[p] <= 1'b0;
        end else begin
          occ[p] <= occ[p] + SZ_W'(inc) - SZ_W'(dec);
          if (inc) begin
            off[p] <= off_next;
            wi[p]  <= '0;
          end else if (sel & acc) begin
            wi[p] <= wi[p] + WO_W'(1);
          end
          if (sel & drop) overflow[p] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else if (wr_en & wr_err & ~wr_eop) proto_err <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (acc) mem[{line_a, wi[wr_part]}] <= {wr_err & wr_eop, wr_eop, wr_data};
    rd_q <= mem[rd_addr];
  end

  assign rd_err  = rd_q[DW+1];
  assign rd_eop  = rd_q[DW];
  assign rd_data = rd_q[DW-1:0];

endmodule

module pvfifo_writer_chk #(
  parameter int NPART = 8,
  parameter int PA_W  = 3,
  parameter int SZ_W  = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [PA_W-1:0]             wr_part,
  input logic                        wr_eop,
  input logic                        wr_err,
  input logic [NPART*SZ_W-1:0]       cfg_size,
  input logic [NPART-1:0][SZ_W-1:0]  occ,
  input logic [NPART-1:0]            overflow,
  input logic                        proto_err
);
  logic [SZ_W-1:0] size_a;
  assign size_a = cfg_size[wr_part*SZ_W +: SZ_W];

  a_r3_proto_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  a_r3_proto_on_lone_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_err && !wr_eop) |=> proto_err);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow != '0) |=> ((overflow & $past(overflow)) == $past(overflow)));

  a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && occ[wr_part] == size_a) |=> overflow[$past(wr_part)]);

  genvar p;
  generate
    for (p = 0; p < NPART; p++) begin : g_chk
      a_r8_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        occ[p] <= cfg_size[p*SZ_W +: SZ_W]);
    end
  endgenerate
endmodule

bind pvfifo_writer pvfifo_writer_chk #(.NPART(NPART), .PA_W(PA_W), .SZ_W(SZ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_part(wr_part), .wr_eop(wr_eop),
  .wr_err(wr_err), .cfg_size(cfg_size), .occ(occ), .overflow(overflow),
  .proto_err(proto_err));

// File: tb/tb_pvfifo_writer.sv
module tb_pvfifo_writer;
  localparam int DW = 32, NPART = 8, LINES = 16, WPL = 4;
  localparam int LA_W = 4, WO_W = 2, SZ_W = 5;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_eop = 0, wr_err = 0, wr_term = 0;
  logic [2:0] wr_part = 0;
  logic [DW-1:0] wr_data = 0;
  logic [NPART*LA_W-1:0] cfg_base;
  logic [NPART*SZ_W-1:0] cfg_size, cfg_level;
  logic [NPART-1:0] pop = 0;
  logic [LA_W+WO_W-1:0] rd_addr = 0;
  logic full, proto_err, rd_eop, rd_err;
  logic [NPART-1:0] overflow;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pvfifo_writer dut (.*);

  initial begin
    for (int p = 0; p < NPART; p++) begin
      cfg_base[p*LA_W +: LA_W]   = LA_W'(2*p);
      cfg_size[p*SZ_W +: SZ_W]   = SZ_W'(2);
      cfg_level[p*SZ_W +: SZ_W]  = SZ_W'(p % 2);
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int p, logic [DW-1:0] d, logic eop, logic err, logic term, logic en = 1);
    wr_part = 3'(p); wr_data = d; wr_eop = eop; wr_err = err; wr_term = term; wr_en = en;
    @(negedge clk);
    wr_en = 0; wr_eop = 0; wr_err = 0; wr_term = 0;
  endtask

  task automatic popp(int p);
    pop = NPART'(1) << p;
    @(negedge clk);
    pop = 0;
  endtask

  task automatic rdchk(string req, int addr, logic [DW-1:0] d, logic eop, logic err);
    rd_addr = 6'(addr);
    @(negedge clk);
    chk(req, {30'd0, rd_err, rd_eop, rd_data}, {30'd0, err, eop, d});
  endtask

  task automatic fullchk(string req, int p, logic exp);
    wr_part = 3'(p);
    #0;
    #1 chk(req, 64'(full), 64'(exp));
  endtask

  function automatic logic [DW-1:0] pat(int step, int p, int i);
    return {8'(step), 8'hC0, 8'(p), 8'(i)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    for (int p = 0; p < NPART; p++) fullchk("R9 full", p, 0);
    chk("R9 overflow", 64'(overflow), 0);
    chk("R9 proto_err", 64'(proto_err), 0);
    rst_n = 1;
    @(negedge clk);

    for (int p = 0; p < NPART; p++) begin
      // R1: four words fill one line
      for (int i = 0; i < WPL; i++) wr(p, pat(1, p, i), 0, 0, 0);
      fullchk("R1 R6 full after one line", p, (p % 2) == 0);
      for (int i = 0; i < WPL; i++) rdchk("R1 R10 line data", (2*p)*WPL + i, pat(1, p, i), 0, 0);
      // R2 R3: eop with err tags and ends line
      wr(p, pat(2, p, 0), 1, 1, 0);
      fullchk("R2 R6 full after second line", p, 1);
      rdchk("R2 R3 eop+err tag", (2*p+1)*WPL, pat(2, p, 0), 1, 1);
      // R7: partition at size -> dropped
      wr(p, pat(3, p, 0), 0, 0, 0);
      chk("R7 overflow bit", 64'(overflow[p]), 1);
      rdchk("R7 memory untouched", (2*p)*WPL, pat(1, p, 0), 0, 0);
      rdchk("R7 memory untouched line1", (2*p+1)*WPL, pat(2, p, 0), 1, 1);
      // R8: pops, including one on empty
      popp(p);
      fullchk("R8 R6 full after one pop", p, (p % 2) == 0);
      popp(p);
      popp(p);
      fullchk("R8 full after empty pop", p, 0);
      // R4 R5: write with term wraps to base line
      wr(p, pat(4, p, 0), 0, 0, 1);
      wr(p, pat(4, p, 1), 0, 0, 0);
      rdchk("R4 R5 wrap to base", (2*p)*WPL, pat(4, p, 0), 0, 0);
      rdchk("R4 next line after term", (2*p+1)*WPL, pat(4, p, 1), 0, 0);
      fullchk("R8 occupancy one after underflow attempt", p, (p % 2) == 0);
      // R4: term alone
      wr(p, 0, 0, 0, 1, 0);
      fullchk("R4 term alone counts line", p, 1);
      popp(p);
      wr(p, pat(5, p, 0), 0, 0, 0);
      rdchk("R4 R5 after lone term", (2*p)*WPL, pat(5, p, 0), 0, 0);
      rdchk("R4 partial line intact", (2*p+1)*WPL, pat(4, p, 1), 0, 0);
    end
    chk("R7 all overflow", 64'(overflow), 64'hFF);
    chk("R3 no proto_err yet", 64'(proto_err), 0);
    // R3: err without eop
    wr(0, pat(6, 0, 1), 0, 1, 0);
    chk("R3 proto_err set", 64'(proto_err), 1);
    rdchk("R3 lone err not tagged", 1, pat(6, 0, 1), 0, 0);
    wr(0, pat(6, 0, 2), 0, 0, 0);
    chk("R3 proto_err sticky", 64'(proto_err), 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule